// File: doc/BRIEF.md
# Interlace-Capable Vertical Timing Generator

This block produces the vertical part of a raster timing set: an active-low vertical blank, an active-low vertical sync and an odd/even field flag. It holds no horizontal counter. It takes single-cycle strobes from a horizontal generator and counts them. In progressive mode it counts whole lines. In interlaced mode it counts half-lines. Every vertical setting is given per frame, not per field, in both modes. The frame length is always given in whole lines. The sync and blank thresholds are given in counting units, including the offset of one for the first edge.

The position in the frame is tracked by a four-state machine over the current count:
- `ZN_FRONT`: blanked, before sync.
- `ZN_SYNC`: sync interval.
- `ZN_BACK`: blanked, after sync.
- `ZN_ACTIVE`: picture.

The machine has the following transitions:
- FRONT→SYNC when the count reaches `vsync_start`.
- SYNC→BACK when the count reaches `vsync_stop`.
- BACK→ACTIVE when the count reaches `vblank_stop`.
- ACTIVE→FRONT when the count wraps to 1.
- A state may pass through a zero-length zone in the same step.

The blank output takes its value from this state only on a horizontal-blank strobe. The sync output takes its value only on a horizontal-sync strobe. As a result, each edge lines up with the matching horizontal edge.

Top module: `vert_timing_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `vblank_n`=0, `vsync_n`=1 and `field_odd`=0, and the count is 1.
- R2: With `interlace`=0, the count advances by one on each `hblank_lead` strobe. It returns to 1 after reaching `frame_lines`, so a frame lasts `frame_lines` lines. `half_tick` has no effect in this mode.
- R3: With `interlace`=1, the count advances on each `hblank_lead` and on each `half_tick`. It returns to 1 after reaching 2×`frame_lines`, so a frame lasts `frame_lines` whole lines.
- R4: `vblank_n` is 0 while the count lies in 1 to `vblank_stop`−1, so the blank is `vblank_stop`−1 counts wide. It is 1 otherwise. It is updated only in the clock cycle of an `hblank_lead` strobe, and it uses the count after that strobe's advance.
- R5: `vsync_n` is 0 while the count lies in `vsync_start` to `vsync_stop`−1. This gives a front porch of `vsync_start`−1 counts and a sync of `vsync_stop`−`vsync_start` counts. It is updated only on an `hsync_lead` strobe.
- R6: With `interlace`=1, `field_odd` is 1 while the count exceeds `frame_lines`, which is the second half of the frame. It is updated on count advances. With `interlace`=0 it stays 0.
- R7: An `hsync_lead` strobe never changes `vblank_n`, and an `hblank_lead` strobe never changes `vsync_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank_lead | input | 1 | One-cycle strobe at the leading edge of horizontal blank |
| hsync_lead | input | 1 | One-cycle strobe at the leading edge of horizontal sync |
| half_tick | input | 1 | One-cycle strobe at mid-line |
| interlace | input | 1 | 1 = count half-lines, 0 = count whole lines |
| vsync_start | input | LINE_W+1 | First count of vertical sync (front porch + 1) |
| vsync_stop | input | LINE_W+1 | First count after vertical sync |
| vblank_stop | input | LINE_W+1 | First count after vertical blank |
| frame_lines | input | LINE_W | Frame length in whole lines |
| vblank_n | output | 1 | Vertical blank, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | Second-field flag |

## Verification
The assertions rely on the following conditions on the inputs:
- Every strobe lasts a single cycle.
- `half_tick` never coincides with `hblank_lead`.
- The settings satisfy 2 ≤ `vsync_start` ≤ `vsync_stop` ≤ `vblank_stop` ≤ the wrap count.
- The mode and the settings change only while reset is held.

The stimulus drives a fixed line pattern in which blank comes first, sync a few cycles later and the half-line tick at mid-line, and it never overlaps these strobes. It applies reset before loading each new setting. It also keeps sending `half_tick` in progressive mode, so that the no-effect case of R2 is exercised at the ports.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic [1:0] {
        ZN_FRONT,
        ZN_SYNC,
        ZN_BACK,
        ZN_ACTIVE
    } zone_e;
endpackage

// File: rtl/vtg_line_counter.sv
module vtg_line_counter #(
    parameter int HL_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            interlace,
    input  logic [HL_W-1:0] wrap_at,
    input  logic [HL_W-1:0] half_point,
    output logic [HL_W-1:0] cnt_q,
    output logic [HL_W-1:0] cnt_nx,
    output logic            field_odd
);
    localparam logic [HL_W-1:0] ONE = HL_W'(1);

    always_comb begin
        cnt_nx = cnt_q;
        if (tick) begin
            cnt_nx = (cnt_q >= wrap_at) ? ONE : cnt_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= ONE;
            field_odd <= 1'b0;
        end else if (tick) begin
            cnt_q     <= cnt_nx;
            field_odd <= interlace && (cnt_nx > half_point);
        end
    end
endmodule

// File: rtl/vtg_zone_fsm.sv
module vtg_zone_fsm
    import vtg_pkg::*;
#(
    parameter int HL_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HL_W-1:0] cnt_nx,
    input  logic [HL_W-1:0] sync_first,
    input  logic [HL_W-1:0] sync_after,
    input  logic [HL_W-1:0] blank_after,
    output zone_e           zone_q,
    output zone_e           zone_nx
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_q <= ZN_FRONT;
        end else begin
            zone_q <= zone_nx;
        end
    end

    always_comb begin
        zone_nx = zone_q;
        unique case (zone_q)
            ZN_FRONT: begin
                if (cnt_nx >= blank_after)     zone_nx = ZN_ACTIVE;
                else if (cnt_nx >= sync_after) zone_nx = ZN_BACK;
                else if (cnt_nx >= sync_first) zone_nx = ZN_SYNC;
            end
            ZN_SYNC: begin
                if (cnt_nx >= blank_after)     zone_nx = ZN_ACTIVE;
                else if (cnt_nx >= sync_after) zone_nx = ZN_BACK;
            end
            ZN_BACK: begin
                if (cnt_nx >= blank_after)     zone_nx = ZN_ACTIVE;
            end
            ZN_ACTIVE: begin
                if (cnt_nx < blank_after) begin
                    if (cnt_nx < sync_first)      zone_nx = ZN_FRONT;
                    else if (cnt_nx < sync_after) zone_nx = ZN_SYNC;
                    else                          zone_nx = ZN_BACK;
                end
            end
            default: zone_nx = ZN_FRONT;
        endcase
    end
endmodule

// File: rtl/vtg_edge_retimer.sv
module vtg_edge_retimer
    import vtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  blank_edge,
    input  logic  sync_edge,
    input  zone_e zone_nx,
    output logic  vblank_n,
    output logic  vsync_n
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vblank_n <= 1'b0;
            vsync_n  <= 1'b1;
        end else begin
            if (blank_edge) vblank_n <= (zone_nx == ZN_ACTIVE);
            if (sync_edge)  vsync_n  <= (zone_nx != ZN_SYNC);
        end
    end
endmodule

// File: rtl/vert_timing_gen.sv
module vert_timing_gen
    import vtg_pkg::*;
#(
    parameter int LINE_W = 11,
    localparam int HL_W  = LINE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank_lead,
    input  logic              hsync_lead,
    input  logic              half_tick,
    input  logic              interlace,
    input  logic [HL_W-1:0]   vsync_start,
    input  logic [HL_W-1:0]   vsync_stop,
    input  logic [HL_W-1:0]   vblank_stop,
    input  logic [LINE_W-1:0] frame_lines,
    output logic              vblank_n,
    output logic              vsync_n,
    output logic              field_odd
);
    logic            tick;
    logic [HL_W-1:0] wrap_at;
    logic [HL_W-1:0] half_point;
    logic [HL_W-1:0] cnt_q;
    logic [HL_W-1:0] cnt_nx;
    zone_e           zone_q;
    zone_e           zone_nx;

    assign tick       = hblank_lead | (interlace & half_tick);
    assign half_point = {1'b0, frame_lines};
    assign wrap_at    = interlace ? {frame_lines, 1'b0} : {1'b0, frame_lines};

    vtg_line_counter #(.HL_W(HL_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .interlace  (interlace),
        .wrap_at    (wrap_at),
        .half_point (half_point),
        .cnt_q      (cnt_q),
        .cnt_nx     (cnt_nx),
        .field_odd  (field_odd)
    );

    vtg_zone_fsm #(.HL_W(HL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_nx      (cnt_nx),
        .sync_first  (vsync_start),
        .sync_after  (vsync_stop),
        .blank_after (vblank_stop),
        .zone_q      (zone_q),
        .zone_nx     (zone_nx)
    );

    vtg_edge_retimer u_retime (
        .clk        (clk),
        .rst_n      (rst_n),
        .blank_edge (hblank_lead),
        .sync_edge  (hsync_lead),
        .zone_nx    (zone_nx),
        .vblank_n   (vblank_n),
        .vsync_n    (vsync_n)
    );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
    parameter int LINE_W = 11,
    parameter int HL_W   = LINE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hblank_lead,
    input logic              hsync_lead,
    input logic              interlace,
    input logic [LINE_W-1:0] frame_lines,
    input logic [HL_W-1:0]   cnt_q,
    input logic              vblank_n,
    input logic              vsync_n,
    input logic              field_odd
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!vblank_n && vsync_n && !field_odd && cnt_q == HL_W'(1))); // R1
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0); // R2
    AST_CNT_CEIL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        !interlace |-> cnt_q <= {1'b0, frame_lines}); // R2
    AST_CNT_CEIL_INTL: assert property (@(posedge clk) disable iff (!rst_n)
        interlace |-> cnt_q <= {frame_lines, 1'b0}); // R3
    AST_BLANK_RETIME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank_n) |-> $past(hblank_lead)); // R4
    AST_SYNC_RETIME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsync_n) |-> $past(hsync_lead)); // R5
    AST_FIELD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(field_odd) |-> $past(interlace)); // R6
    AST_SYNC_KEEPS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_lead && !hblank_lead) |=> $stable(vblank_n)); // R7
endmodule

bind vert_timing_gen vtg_checker #(.LINE_W(LINE_W), .HL_W(HL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hblank_lead (hblank_lead),
    .hsync_lead  (hsync_lead),
    .interlace   (interlace),
    .frame_lines (frame_lines),
    .cnt_q       (cnt_q),
    .vblank_n    (vblank_n),
    .vsync_n     (vsync_n),
    .field_odd   (field_odd)
);

// File: tb/vert_timing_gen_tb.sv
`timescale 1ns/1ps
module vert_timing_gen_tb;
    localparam int LINE_W = 11;
    localparam int HL_W   = LINE_W + 1;

    typedef struct {
        logic blank_n;
        logic sync_n;
        logic field;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hblank_lead = 1'b0;
    logic              hsync_lead = 1'b0;
    logic              half_tick = 1'b0;
    logic              interlace = 1'b0;
    logic [HL_W-1:0]   vsync_start = HL_W'(3);
    logic [HL_W-1:0]   vsync_stop = HL_W'(5);
    logic [HL_W-1:0]   vblank_stop = HL_W'(7);
    logic [LINE_W-1:0] frame_lines = LINE_W'(10);
    logic              vblank_n;
    logic              vsync_n;
    logic              field_odd;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    int   m_cnt;
    logic m_blank_n;
    logic m_sync_n;
    logic m_field;

    always #10 clk = ~clk;

    vert_timing_gen #(.LINE_W(LINE_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hblank_lead (hblank_lead),
        .hsync_lead  (hsync_lead),
        .half_tick   (half_tick),
        .interlace   (interlace),
        .vsync_start (vsync_start),
        .vsync_stop  (vsync_stop),
        .vblank_stop (vblank_stop),
        .frame_lines (frame_lines),
        .vblank_n    (vblank_n),
        .vsync_n     (vsync_n),
        .field_odd   (field_odd)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // kind: 0 = horizontal blank strobe, 1 = horizontal sync strobe, 2 = half-line tick
    task automatic strobe(input int kind);
        int   lim;
        logic adv;
        exp_t e;
        @(negedge clk);
        hblank_lead = (kind == 0);
        hsync_lead  = (kind == 1);
        half_tick   = (kind == 2);
        lim = interlace ? 2 * int'(frame_lines) : int'(frame_lines);
        adv = (kind == 0) || (interlace && kind == 2);
        if (adv) begin
            m_cnt   = (m_cnt >= lim) ? 1 : m_cnt + 1;
            m_field = interlace && (m_cnt > int'(frame_lines));
        end
        if (kind == 0) m_blank_n = !(m_cnt < int'(vblank_stop));
        if (kind == 1) m_sync_n  = !(m_cnt >= int'(vsync_start) && m_cnt < int'(vsync_stop));
        e.blank_n = m_blank_n;
        e.sync_n  = m_sync_n;
        e.field   = m_field;
        sb.push_back(e);
        @(negedge clk);
        hblank_lead = 1'b0;
        hsync_lead  = 1'b0;
        half_tick   = 1'b0;
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) begin
            strobe(0);
            repeat (2) @(negedge clk);
            strobe(1);
            repeat (4) @(negedge clk);
            strobe(2);
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic do_reset(input logic il, input int vt, input int s0, input int s1, input int b1);
        @(negedge clk);
        rst_n       = 1'b0;
        interlace   = il;
        frame_lines = LINE_W'(vt);
        vsync_start = HL_W'(s0);
        vsync_stop  = HL_W'(s1);
        vblank_stop = HL_W'(b1);
        repeat (3) @(negedge clk);
        check("R1 blank in reset", vblank_n, 1'b0);
        check("R1 sync in reset", vsync_n, 1'b1);
        check("R1 field in reset", field_odd, 1'b0);
        rst_n = 1'b1;
        m_cnt = 1;
        m_blank_n = 1'b0;
        m_sync_n  = 1'b1;
        m_field   = 1'b0;
        @(negedge clk);
        check("R1 blank after release", vblank_n, 1'b0);
        check("R1 sync after release", vsync_n, 1'b1);
    endtask

    // Scoreboard monitor: compares each expected item just after the edge that applies it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check("R4 vblank_n", vblank_n, e.blank_n);
                check("R5 vsync_n / R7", vsync_n, e.sync_n);
                check("R6 field_odd / R2 R3 count", field_odd, e.field);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2 R4 R5: progressive, half_tick ignored, two and a half frames
        do_reset(1'b0, 10, 3, 5, 7);
        run_lines(25);
        // R3 R6: interlaced, 9-line frame counted in half-lines
        do_reset(1'b1, 9, 4, 8, 13);
        run_lines(20);
        // R4 R5 boundary: shortest zones, one-count sync
        do_reset(1'b0, 5, 2, 3, 4);
        run_lines(12);
        // R5 zero-width sync, blank ending exactly at wrap
        do_reset(1'b1, 4, 3, 3, 8);
        run_lines(10);
        // R1: reset mid-frame
        run_lines(3);
        do_reset(1'b0, 10, 3, 5, 7);
        run_lines(2);
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule